// File: doc/BRIEF.md
# Subsystem Power Domain Sequencer

This block walks one switchable power island (a video, display, modem or infrastructure island, for example) between its on and off states. It owns the island's two power switch enables, the isolation clamp, the active-low island reset, the clock gate, a four-bit SRAM power-down field and a bus fence request. It steps these outputs through a fixed order. At each step that needs one, it waits for the matching confirmation: power-good from both switch chains, SRAM acknowledge bits, or fence status bits.

A request gives a direction: 1 powers the island up and 0 powers it down. The request is latched and serviced as soon as the sequencer is idle. A single-cycle `done_o` marks the end of a sequence. Every wait has a cycle limit. When a wait runs past that limit, the sequencer stops, freezes all of its outputs and raises `err_o` until reset.

Parameters set the island variant. `USE_PROT` enables or removes the bus fence. `SRAM_MODE` selects no SRAM step (0), a single SRAM power-down bit with no acknowledge wait (1), or the full four-bit field with an acknowledge wait (2). `ACK_W` sets the number of acknowledge bits, which must all agree. `PROT_MASK` sets which fence lines the island uses.

Top module: `pdc_top`

## Requirements
- R1: Out of reset the island is held off. Both switch enables are 0, isolation is 1, `rst_no` is 0 and clock disable is 1. `sram_pdn_o` is 4'hF in mode 2, 4'h1 in mode 1 and 4'h0 in mode 0. `prot_req_o` equals `PROT_MASK` when the fence is used and 0 otherwise. `done_o` and `err_o` are both 0.
- R2: With the fence enabled, power-down first drives `prot_req_o` to `PROT_MASK`. Nothing else changes until every `prot_sta_i` bit under the mask reads 1.
- R3: Power-down then sets `sram_pdn_o` to 4'hF (mode 2). Isolation does not rise until all `ACK_W` bits of `sram_ack_i` read 1.
- R4: Power-down continues in this order. First isolation rises. On the next step, clock disable rises and `rst_no` falls in the same cycle. On the step after that, both switch enables fall together. `done_o` comes only after `pgood_i` and `pgood2_i` both read 0.
- R5: Power-up raises the primary switch enable one step before the secondary. It then waits for both power-good inputs to read 1. After that it clears clock disable, then clears isolation, then raises `rst_no`, each on its own successive step.
- R6: After reset release, power-up clears `sram_pdn_o` to 0 (mode 2). It does not continue until all acknowledge bits read 0.
- R7: The fence is released last: `prot_req_o` returns to 0. `done_o` follows only after every masked `prot_sta_i` bit reads 0.
- R8: With `USE_PROT`=0, `prot_req_o` stays 0 at all times and `prot_sta_i` has no effect on the sequence.
- R9: In mode 1, only bit 0 of `sram_pdn_o` is driven: it is 1 when the island is off and 0 when it is on. `sram_ack_i` has no effect.
- R10: A request that arrives while a sequence runs is held and executed once that sequence ends. Only one request is held, and a later request replaces the held one's direction.
- R11: If any wait lasts `WAIT_LIMIT` cycles, `err_o` rises and all island outputs hold their values. No `done_o` is produced, and further requests are ignored until reset.
- R12: `done_o` is a one-cycle pulse, given once for each completed sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle sequence request |
| dir_i | input | 1 | Request direction: 1 power up, 0 power down |
| sram_ack_i | input | ACK_W | SRAM power-down acknowledge bits |
| prot_sta_i | input | PROT_W | Bus fence status lines |
| pgood_i | input | 1 | Power-good of the primary switch chain |
| pgood2_i | input | 1 | Power-good of the secondary switch chain |
| sw_en_o | output | 1 | Primary power switch enable |
| sw_en2_o | output | 1 | Secondary power switch enable |
| iso_o | output | 1 | Isolation clamp enable |
| rst_no | output | 1 | Island reset, active low |
| clk_dis_o | output | 1 | Island clock disable |
| sram_pdn_o | output | 4 | SRAM power-down field |
| prot_req_o | output | PROT_W | Bus fence request lines |
| done_o | output | 1 | Sequence complete pulse |
| err_o | output | 1 | Wait timeout, held until reset |

## Verification
The bench instantiates the block twice.

The first instance has the fence enabled, `PROT_MASK`=8'h5A, the full SRAM mode with two acknowledge bits and `WAIT_LIMIT`=40. It runs against an island model whose response latency changes per test vector. With this instance, the bench can measure the cycle spacing between steps against that latency, exercise the held-request path, and, by freezing power-good, force a timeout.

The second instance has no fence and uses the single-bit SRAM mode. Its acknowledge input is tied high and its fence status is tied low, so the sequence can only complete if both inputs are truly ignored.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int PDN_W       = 4;
  localparam int SRAM_NONE   = 0;
  localparam int SRAM_SINGLE = 1;
  localparam int SRAM_FULL   = 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DN_PROT,
    S_DN_SRAM,
    S_DN_ISO,
    S_DN_CLK,
    S_DN_SW,
    S_UP_SW1,
    S_UP_SW2,
    S_UP_CLK,
    S_UP_ISO,
    S_UP_RST,
    S_UP_SRAM,
    S_UP_PROT,
    S_ERR
  } pdc_state_e;
endpackage

// File: rtl/pdc_req_queue.sv
module pdc_req_queue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic dir_i,
  input  logic flush_i,
  input  logic take_i,
  output logic pend_o,
  output logic dir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      dir_o  <= 1'b0;
    end else if (flush_i) begin
      pend_o <= 1'b0;
    end else if (req_i) begin
      pend_o <= 1'b1;
      dir_o  <= dir_i;
    end else if (take_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pdc_wait_timer.sv
module pdc_wait_timer #(
  parameter int WAIT_LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (run_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LIMIT);
endmodule

// File: rtl/pdc_seq_fsm.sv
module pdc_seq_fsm
  import pdc_pkg::*;
#(
  parameter bit               USE_PROT  = 1'b1,
  parameter int               SRAM_MODE = SRAM_FULL,
  parameter int               ACK_W     = 4,
  parameter int               PROT_W    = 8,
  parameter logic [PROT_W-1:0] PROT_MASK = 8'h0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic              pend_dir_i,
  input  logic              expired_i,
  input  logic [ACK_W-1:0]  sram_ack_i,
  input  logic [PROT_W-1:0] prot_sta_i,
  input  logic              pgood_i,
  input  logic              pgood2_i,
  output logic              take_o,
  output logic              step_o,
  output logic              wait_o,
  output logic              sw_en_o,
  output logic              sw_en2_o,
  output logic              iso_o,
  output logic              rst_no,
  output logic              clk_dis_o,
  output logic [PDN_W-1:0]  sram_pdn_o,
  output logic [PROT_W-1:0] prot_req_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [PDN_W-1:0] PDN_SET =
    (SRAM_MODE == SRAM_FULL)   ? {PDN_W{1'b1}} :
    (SRAM_MODE == SRAM_SINGLE) ? PDN_W'(1)     : '0;
  localparam logic [PROT_W-1:0] PROT_RST  = USE_PROT ? PROT_MASK : '0;
  localparam bit                ACK_CHECK = (SRAM_MODE == SRAM_FULL);
  localparam bit                HAS_SRAM  = (SRAM_MODE != SRAM_NONE);

  pdc_state_e st_q, st_d;
  logic       cond, waiting, finish;

  function automatic pdc_state_e follow(input pdc_state_e s);
    pdc_state_e n;
    case (s)
      S_DN_PROT: n = HAS_SRAM ? S_DN_SRAM : S_DN_ISO;
      S_DN_SRAM: n = S_DN_ISO;
      S_DN_ISO:  n = S_DN_CLK;
      S_DN_CLK:  n = S_DN_SW;
      S_DN_SW:   n = S_IDLE;
      S_UP_SW1:  n = S_UP_SW2;
      S_UP_SW2:  n = S_UP_CLK;
      S_UP_CLK:  n = S_UP_ISO;
      S_UP_ISO:  n = S_UP_RST;
      S_UP_RST:  n = HAS_SRAM ? S_UP_SRAM : (USE_PROT ? S_UP_PROT : S_IDLE);
      S_UP_SRAM: n = USE_PROT ? S_UP_PROT : S_IDLE;
      default:   n = S_IDLE;
    endcase
    return n;
  endfunction

  // wait condition of the current step
  always_comb begin
    cond    = 1'b1;
    waiting = 1'b0;
    case (st_q)
      S_DN_PROT: begin
        waiting = 1'b1;
        cond    = (prot_sta_i & PROT_MASK) == PROT_MASK;
      end
      S_DN_SRAM: begin
        waiting = ACK_CHECK;
        cond    = !ACK_CHECK || (&sram_ack_i);
      end
      S_DN_SW: begin
        waiting = 1'b1;
        cond    = !pgood_i && !pgood2_i;
      end
      S_UP_SW2: begin
        waiting = 1'b1;
        cond    = pgood_i && pgood2_i;
      end
      S_UP_SRAM: begin
        waiting = ACK_CHECK;
        cond    = !ACK_CHECK || !(|sram_ack_i);
      end
      S_UP_PROT: begin
        waiting = 1'b1;
        cond    = (prot_sta_i & PROT_MASK) == '0;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    take_o = 1'b0;
    finish = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (pend_i) begin
          take_o = 1'b1;
          if (pend_dir_i)    st_d = S_UP_SW1;
          else if (USE_PROT) st_d = S_DN_PROT;
          else if (HAS_SRAM) st_d = S_DN_SRAM;
          else               st_d = S_DN_ISO;
        end
      end
      S_ERR: ;
      default: begin
        if (cond) begin
          st_d   = follow(st_q);
          finish = (st_d == S_IDLE);
        end else if (expired_i) begin
          st_d = S_ERR;
        end
      end
    endcase
  end

  assign step_o = (st_d != st_q);
  assign wait_o = waiting && !cond;
  assign err_o  = (st_q == S_ERR);

  // each step applies its action on entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      done_o     <= 1'b0;
      sw_en_o    <= 1'b0;
      sw_en2_o   <= 1'b0;
      iso_o      <= 1'b1;
      rst_no     <= 1'b0;
      clk_dis_o  <= 1'b1;
      sram_pdn_o <= PDN_SET;
      prot_req_o <= PROT_RST;
    end else begin
      st_q   <= st_d;
      done_o <= finish;
      if (st_d != st_q) begin
        case (st_d)
          S_DN_PROT: prot_req_o <= PROT_MASK;
          S_DN_SRAM: sram_pdn_o <= PDN_SET;
          S_DN_ISO:  iso_o      <= 1'b1;
          S_DN_CLK: begin
            clk_dis_o <= 1'b1;
            rst_no    <= 1'b0;
          end
          S_DN_SW: begin
            sw_en_o  <= 1'b0;
            sw_en2_o <= 1'b0;
          end
          S_UP_SW1:  sw_en_o    <= 1'b1;
          S_UP_SW2:  sw_en2_o   <= 1'b1;
          S_UP_CLK:  clk_dis_o  <= 1'b0;
          S_UP_ISO:  iso_o      <= 1'b0;
          S_UP_RST:  rst_no     <= 1'b1;
          S_UP_SRAM: sram_pdn_o <= '0;
          S_UP_PROT: prot_req_o <= '0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pdc_top.sv
module pdc_top
  import pdc_pkg::*;
#(
  parameter bit               USE_PROT   = 1'b1,
  parameter int               SRAM_MODE  = SRAM_FULL,
  parameter int               ACK_W      = 4,
  parameter int               PROT_W     = 8,
  parameter logic [PROT_W-1:0] PROT_MASK  = 8'h0F,
  parameter int               WAIT_LIMIT = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              dir_i,
  input  logic [ACK_W-1:0]  sram_ack_i,
  input  logic [PROT_W-1:0] prot_sta_i,
  input  logic              pgood_i,
  input  logic              pgood2_i,
  output logic              sw_en_o,
  output logic              sw_en2_o,
  output logic              iso_o,
  output logic              rst_no,
  output logic              clk_dis_o,
  output logic [3:0]        sram_pdn_o,
  output logic [PROT_W-1:0] prot_req_o,
  output logic              done_o,
  output logic              err_o
);
  logic pend, pend_dir, take, step, waiting, expired;

  pdc_req_queue u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .dir_i   (dir_i),
    .flush_i (err_o),
    .take_i  (take),
    .pend_o  (pend),
    .dir_o   (pend_dir)
  );

  pdc_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (step),
    .run_i     (waiting),
    .expired_o (expired)
  );

  pdc_seq_fsm #(
    .USE_PROT  (USE_PROT),
    .SRAM_MODE (SRAM_MODE),
    .ACK_W     (ACK_W),
    .PROT_W    (PROT_W),
    .PROT_MASK (PROT_MASK)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend),
    .pend_dir_i (pend_dir),
    .expired_i  (expired),
    .sram_ack_i (sram_ack_i),
    .prot_sta_i (prot_sta_i),
    .pgood_i    (pgood_i),
    .pgood2_i   (pgood2_i),
    .take_o     (take),
    .step_o     (step),
    .wait_o     (waiting),
    .sw_en_o    (sw_en_o),
    .sw_en2_o   (sw_en2_o),
    .iso_o      (iso_o),
    .rst_no     (rst_no),
    .clk_dis_o  (clk_dis_o),
    .sram_pdn_o (sram_pdn_o),
    .prot_req_o (prot_req_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk
  import pdc_pkg::*;
#(
  parameter bit               USE_PROT  = 1'b1,
  parameter int               SRAM_MODE = SRAM_FULL,
  parameter int               ACK_W     = 4,
  parameter int               PROT_W    = 8,
  parameter logic [PROT_W-1:0] PROT_MASK = 8'h0F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ACK_W-1:0]  sram_ack_i,
  input logic [PROT_W-1:0] prot_sta_i,
  input logic              pgood_i,
  input logic              pgood2_i,
  input logic              sw_en_o,
  input logic              sw_en2_o,
  input logic              iso_o,
  input logic              rst_no,
  input logic              clk_dis_o,
  input logic [3:0]        sram_pdn_o,
  input logic [PROT_W-1:0] prot_req_o,
  input logic              done_o,
  input logic              err_o
);
  // R4
  sw_off_fenced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_en_o) |-> iso_o && clk_dis_o && !rst_no && !sw_en2_o);

  // R4
  clk_rst_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_dis_o) |-> iso_o && !rst_no);

  // R5
  sw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en2_o) |-> $past(sw_en_o));

  // R5
  pg_before_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_dis_o) |-> $past(pgood_i) && $past(pgood2_i));

  // R5
  iso_after_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_o) |-> !clk_dis_o && sw_en_o && sw_en2_o);

  // R5
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> !iso_o && !clk_dis_o);

  // R11
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && !done_o &&
      $stable({sw_en_o, sw_en2_o, iso_o, rst_no, clk_dis_o, sram_pdn_o, prot_req_o}));

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  generate
    if (USE_PROT) begin : g_prot
      // R2
      iso_fenced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(iso_o) |-> prot_req_o == PROT_MASK);
      // R7
      done_unfenced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && rst_no) |-> prot_req_o == '0 && ($past(prot_sta_i) & PROT_MASK) == '0);
      if (SRAM_MODE != SRAM_NONE) begin : g_prot_sram
        // R2
        sram_after_fence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          $rose(|sram_pdn_o) |-> ($past(prot_sta_i) & PROT_MASK) == PROT_MASK);
      end
    end else begin : g_noprot
      // R8
      no_fence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prot_req_o == '0);
    end
    if (SRAM_MODE == SRAM_FULL) begin : g_full
      // R3
      ack_before_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(iso_o) |-> (&$past(sram_ack_i)) && sram_pdn_o == 4'hF);
      if (USE_PROT) begin : g_full_prot
        // R6
        ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          $fell(|prot_req_o) |-> sram_pdn_o == 4'h0 && !(|$past(sram_ack_i)));
      end
    end
    if (SRAM_MODE == SRAM_SINGLE) begin : g_single
      // R9
      single_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sram_pdn_o[3:1] == 3'b000);
    end
  endgenerate
endmodule

bind pdc_top pdc_chk #(
  .USE_PROT  (USE_PROT),
  .SRAM_MODE (SRAM_MODE),
  .ACK_W     (ACK_W),
  .PROT_W    (PROT_W),
  .PROT_MASK (PROT_MASK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sram_ack_i (sram_ack_i),
  .prot_sta_i (prot_sta_i),
  .pgood_i    (pgood_i),
  .pgood2_i   (pgood2_i),
  .sw_en_o    (sw_en_o),
  .sw_en2_o   (sw_en2_o),
  .iso_o      (iso_o),
  .rst_no     (rst_no),
  .clk_dis_o  (clk_dis_o),
  .sram_pdn_o (sram_pdn_o),
  .prot_req_o (prot_req_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/sim_pdc_top.sv
`timescale 1ns/1ps
module sim_pdc_top;
  localparam logic [7:0] MASK  = 8'h5A;
  localparam int         LIMIT = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // instance 0: fenced, full SRAM, two ack bits
  logic       req0 = 1'b0, dir0 = 1'b0;
  logic [1:0] ack0;
  logic [7:0] sta0;
  logic       pg0, pg20;
  logic       sw0, sw20, iso0, rstn0, ckd0, done0, err0;
  logic [3:0] pdn0;
  logic [7:0] prot0;

  pdc_top #(.USE_PROT(1'b1), .SRAM_MODE(2), .ACK_W(2), .PROT_W(8),
            .PROT_MASK(MASK), .WAIT_LIMIT(LIMIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req0), .dir_i(dir0),
    .sram_ack_i(ack0), .prot_sta_i(sta0), .pgood_i(pg0), .pgood2_i(pg20),
    .sw_en_o(sw0), .sw_en2_o(sw20), .iso_o(iso0), .rst_no(rstn0),
    .clk_dis_o(ckd0), .sram_pdn_o(pdn0), .prot_req_o(prot0),
    .done_o(done0), .err_o(err0));

  // instance 1: no fence, single SRAM bit; ack tied high, status tied low
  logic       req1 = 1'b0, dir1 = 1'b0;
  logic       pg1, pg21;
  logic       sw1, sw21, iso1, rstn1, ckd1, done1, err1;
  logic [3:0] pdn1;
  logic [7:0] prot1;

  pdc_top #(.USE_PROT(1'b0), .SRAM_MODE(1), .ACK_W(1), .PROT_W(8),
            .PROT_MASK(MASK), .WAIT_LIMIT(LIMIT)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .dir_i(dir1),
    .sram_ack_i(1'b1), .prot_sta_i(8'h00), .pgood_i(pg1), .pgood2_i(pg21),
    .sw_en_o(sw1), .sw_en2_o(sw21), .iso_o(iso1), .rst_no(rstn1),
    .clk_dis_o(ckd1), .sram_pdn_o(pdn1), .prot_req_o(prot1),
    .done_o(done1), .err_o(err1));

  // island model for u0: each response follows its driver after lat cycles
  int lat = 0;
  bit freeze = 1'b0;
  int c_pg, c_pg2, c_ack, c_sta;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg0 <= 1'b0; pg20 <= 1'b0; ack0 <= 2'b11; sta0 <= MASK;
      c_pg <= 0; c_pg2 <= 0; c_ack <= 0; c_sta <= 0;
    end else begin
      if (!freeze && pg0 != sw0) begin
        if (c_pg >= lat) begin pg0 <= sw0; c_pg <= 0; end else c_pg <= c_pg + 1;
      end else c_pg <= 0;
      if (!freeze && pg20 != sw20) begin
        if (c_pg2 >= lat) begin pg20 <= sw20; c_pg2 <= 0; end else c_pg2 <= c_pg2 + 1;
      end else c_pg2 <= 0;
      if (ack0 != pdn0[1:0]) begin
        if (c_ack >= lat) begin ack0 <= pdn0[1:0]; c_ack <= 0; end else c_ack <= c_ack + 1;
      end else c_ack <= 0;
      if (sta0 != prot0) begin
        if (c_sta >= lat) begin sta0 <= prot0; c_sta <= 0; end else c_sta <= c_sta + 1;
      end else c_sta <= 0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin pg1 <= 1'b0; pg21 <= 1'b0; end
    else begin pg1 <= sw1; pg21 <= sw21; end
  end

  // monitor: change times and done counts, sampled on the falling edge
  int t_prot, t_pdn, t_iso, t_ckd, t_rst, t_sw, t_sw2, t_done;
  int dcnt0 = 0, dcnt1 = 0;
  bit prot1_seen = 1'b0;
  logic [7:0] p_prot; logic [3:0] p_pdn;
  logic p_iso, p_ckd, p_rst, p_sw, p_sw2;
  always @(negedge clk) begin
    if (prot0 !== p_prot) t_prot = cyc;
    if (pdn0 !== p_pdn)   t_pdn  = cyc;
    if (iso0 !== p_iso)   t_iso  = cyc;
    if (ckd0 !== p_ckd)   t_ckd  = cyc;
    if (rstn0 !== p_rst)  t_rst  = cyc;
    if (sw0 !== p_sw)     t_sw   = cyc;
    if (sw20 !== p_sw2)   t_sw2  = cyc;
    if (done0) begin t_done = cyc; dcnt0++; end
    if (done1) dcnt1++;
    if (rst_n && prot1 != 8'h00) prot1_seen = 1'b1;
    p_prot = prot0; p_pdn = pdn0; p_iso = iso0; p_ckd = ckd0;
    p_rst = rstn0; p_sw = sw0; p_sw2 = sw20;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pulse0(input logic d);
    @(negedge clk); #1;
    req0 = 1'b1; dir0 = d;
    @(negedge clk); #1;
    req0 = 1'b0;
  endtask

  task automatic pulse1(input logic d);
    @(negedge clk); #1;
    req1 = 1'b1; dir1 = d;
    @(negedge clk); #1;
    req1 = 1'b0;
  endtask

  task automatic wait_cnt0(input int target, output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 400 && !ok; k++) begin
      tick(1);
      if (dcnt0 >= target) ok = 1'b1;
    end
  endtask

  task automatic check_state0(input bit on, input string req);
    if (on) begin
      chk(sw0 && sw20, req, {sw0, sw20}, 3);
      chk(!iso0 && rstn0 && !ckd0, req, {iso0, rstn0, ckd0}, 3'b010);
      chk(pdn0 == 4'h0, req, pdn0, 0);
      chk(prot0 == 8'h00, req, prot0, 0);
    end else begin
      chk(!sw0 && !sw20, req, {sw0, sw20}, 0);
      chk(iso0 && !rstn0 && ckd0, req, {iso0, rstn0, ckd0}, 3'b101);
      chk(pdn0 == 4'hF, req, pdn0, 15);
      chk(prot0 == MASK, req, prot0, MASK);
    end
  endtask

  // vector: bit 4 = direction, bits 3:0 = island response latency
  localparam logic [4:0] VEC [8] = '{
    5'h10, 5'h00, 5'h13, 5'h05, 5'h11, 5'h12, 5'h07, 5'h01
  };

  bit finished = 1'b0;

  initial begin
    bit ok;
    bit on_now;
    int d0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check_state0(1'b0, "R1");
    chk(!done0 && !err0, "R1", {done0, err0}, 0);
    chk(pdn1 == 4'h1 && prot1 == 8'h00, "R1", {pdn1, prot1}, 12'h100);

    on_now = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic dir_v;
      int   l;
      dir_v = VEC[i][4];
      l     = int'(VEC[i][3:0]);
      lat   = l;
      d0    = dcnt0;
      t_prot = -1; t_pdn = -1; t_iso = -1; t_ckd = -1;
      t_rst = -1; t_sw = -1; t_sw2 = -1; t_done = -1;
      pulse0(dir_v);
      wait_cnt0(d0 + 1, ok);
      chk(ok, "R12", dcnt0 - d0, 1);
      tick(1);
      chk(!done0, "R12", done0, 0);
      tick(4);
      chk(dcnt0 == d0 + 1, "R12", dcnt0 - d0, 1);
      check_state0(dir_v, dir_v ? "R5" : "R4");
      if (dir_v != on_now) begin
        if (dir_v) begin
          chk(t_sw2 == t_sw + 1, "R5", t_sw2 - t_sw, 1);
          chk(t_ckd >= t_sw2 + l + 2, "R5", t_ckd - t_sw2, l + 2);
          chk(t_iso == t_ckd + 1 && t_rst == t_iso + 1, "R5", t_rst - t_ckd, 2);
          chk(t_pdn == t_rst + 1, "R6", t_pdn - t_rst, 1);
          chk(t_prot >= t_pdn + l + 2, "R6", t_prot - t_pdn, l + 2);
          chk(t_done >= t_prot + l + 2, "R7", t_done - t_prot, l + 2);
        end else begin
          chk(t_pdn >= t_prot + l + 2, "R2", t_pdn - t_prot, l + 2);
          chk(t_iso >= t_pdn + l + 2, "R3", t_iso - t_pdn, l + 2);
          chk(t_ckd == t_iso + 1 && t_rst == t_ckd, "R4", t_ckd - t_iso, 1);
          chk(t_sw == t_ckd + 1 && t_sw2 == t_sw, "R4", t_sw - t_ckd, 1);
          chk(t_done >= t_sw + l + 2, "R4", t_done - t_sw, l + 2);
        end
      end
      on_now = dir_v;
    end

    // R10 held request: up then down while busy
    lat = 1;
    d0 = dcnt0;
    pulse0(1'b1);
    tick(2);
    pulse0(1'b0);
    wait_cnt0(d0 + 2, ok);
    tick(5);
    chk(ok && dcnt0 == d0 + 2, "R10", dcnt0 - d0, 2);
    check_state0(1'b0, "R10");

    // R10 latest held direction wins
    d0 = dcnt0;
    pulse0(1'b1);
    tick(1);
    pulse0(1'b0);
    pulse0(1'b1);
    wait_cnt0(d0 + 2, ok);
    tick(40);
    chk(ok && dcnt0 == d0 + 2, "R10", dcnt0 - d0, 2);
    check_state0(1'b1, "R10");

    // R8 R9 variant without fence, single SRAM bit
    pulse1(1'b1);
    for (int k = 0; k < 200 && dcnt1 < 1; k++) tick(1);
    tick(2);
    chk(dcnt1 == 1 && !err1, "R8", dcnt1, 1);
    chk(pdn1 == 4'h0 && sw1 && sw21 && rstn1, "R9", pdn1, 0);
    pulse1(1'b0);
    for (int k = 0; k < 200 && dcnt1 < 2; k++) tick(1);
    tick(2);
    chk(dcnt1 == 2 && !err1, "R8", dcnt1, 2);
    chk(pdn1 == 4'h1 && !sw1 && iso1, "R9", pdn1, 1);
    chk(!prot1_seen, "R8", prot1_seen, 0);

    // R11 timeout: power-good frozen high during power-down
    freeze = 1'b1;
    d0 = dcnt0;
    pulse0(1'b0);
    for (int k = 0; k < 300 && !err0; k++) tick(1);
    chk(err0, "R11", err0, 1);
    chk(!sw0 && !sw20 && iso0 && ckd0 && !rstn0, "R11", {sw0, sw20, iso0}, 3'b001);
    pulse0(1'b1);
    tick(30);
    chk(err0 && !sw0 && !sw20 && iso0, "R11", {err0, sw0}, 2'b10);
    chk(dcnt0 == d0, "R11", dcnt0 - d0, 0);

    // R1 reset recovers from error
    #1 rst_n = 1'b0;
    freeze = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(!err0, "R1", err0, 0);
    check_state0(1'b0, "R1");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule